// File: doc/BRIEF.md
# Programmed-I/O Strobe Sequencer

This block turns a single host request into a timed programmed-I/O cycle on a narrow peripheral bus. When a request is accepted, the sequencer runs three timed phases in a fixed order: a lead phase, a strobe phase and a trail phase. Chip-select covers all three phases. The read or write strobe is active only in the middle one. A one-cycle completion pulse follows the access.

The phase lengths come from a configuration word. The word holds one set of lengths for reads and a separate set for writes. Two mode bits in the same word choose between 8-bit and 16-bit accesses and pick which half of the 16-bit bus carries the even-addressed byte. The sequencer places write data on the correct byte lane and gathers read data from the correct lane. It captures read data on the last strobe cycle. Address decode and the host-side protocol are handled elsewhere.

Top module: `pio_strobe_seq`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `dev_cs`, `dev_rd`, `dev_wr` and `dev_oe` are low and `rdata` is zero.
- R2: A request accepted at a clock edge raises `dev_cs` in the next cycle. `dev_cs` then stays high for Llead+Lstrobe+Ltrail consecutive cycles. The strobe is high for exactly the Lstrobe cycles that begin Llead cycles after `dev_cs` rises.
- R3: Each phase lasts its programmed count in cycles, except that a count of zero gives one cycle.
- R4: For reads, the lengths are taken from the configuration word as follows: lead from bit 0, strobe from bits 4:1 and trail from bits 8:5. `dev_rd` is the strobe and `dev_wr` stays low.
- R5: For writes, the lengths are taken as follows: lead from bit 9, strobe from bits 13:10 and trail from bits 17:14. `dev_wr` is the strobe and `dev_rd` stays low. The two strobes are never high together.
- R6: For a read, `rdata` takes the lane-steered value of `dev_din` sampled in the last strobe cycle. It holds that value until the next read.
- R7: `done` is high for exactly one cycle, the cycle right after the last trail cycle, and `dev_cs` is low in that cycle.
- R8: `busy` is high from the first lead cycle through the `done` cycle and low in the cycle after `done`. A request made while `busy` is high is dropped and does not start an access.
- R9: The configuration word is sampled in the accepting cycle. Changing it during an access alters neither the timing nor the lane steering of that access.
- R10: With bit 18 clear, the access is 8 bits wide. The byte travels in `req_wdata[7:0]` and `rdata[7:0]`, and `rdata[15:8]` reads zero. The byte uses bus lane [15:8] when `req_addr0` XOR bit 19 is 1, and lane [7:0] otherwise. The unused lane is driven to zero.
- R11: With bit 18 set, the access is 16 bits wide. `req_wdata[7:0]` and `rdata[7:0]` carry the even byte. With bit 19 clear, the even byte sits on bus bits [7:0]. With bit 19 set, it sits on bits [15:8] and the odd byte sits on bits [7:0].
- R12: During a write, `dev_oe` equals `dev_cs`, and `dev_dout` holds the steered write data for the whole access. During a read, `dev_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, accepted when not busy |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr0 | input | 1 | Low address bit (0 = even byte) |
| req_wdata | input | 16 | Write data, even byte in [7:0] |
| cfg_word | input | 20 | Phase lengths and lane mode bits |
| busy | output | 1 | Access in progress, requests ignored |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, even byte in [7:0] |
| dev_cs | output | 1 | Device chip-select |
| dev_rd | output | 1 | Device read strobe |
| dev_wr | output | 1 | Device write strobe |
| dev_oe | output | 1 | Bus output enable for write data |
| dev_dout | output | 16 | Data driven toward the device |
| dev_din | input | 16 | Data returned by the device |

## Verification
The embedded properties assume three things: reset is asserted at time zero, the request is sampled only on clock edges, and `dev_din` is meaningful only in the last strobe cycle of a read. They make no assumption about when the host changes the configuration word, because the design latches that word itself.

The stimulus covers every lead, strobe and trail count in both directions. It fills the unused direction's length fields with all ones, so taking lengths from the wrong field set shows up as wrong timing. It changes `dev_din` every cycle, so a capture taken in the wrong cycle shows up as wrong read data. It also changes the configuration word and re-asserts the request in the middle of an access.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_LEAD   = 3'd1,
      PH_STROBE = 3'd2,
      PH_TRAIL  = 3'd3,
      PH_DONE   = 3'd4
   } phase_e;

   localparam int unsigned NUM_PHASES = 3;

   function automatic int unsigned max_of3(input int unsigned a, input int unsigned b,
                                           input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/pio_cfg_split.sv
module pio_cfg_split
   import pio_seq_pkg::*;
#(
   parameter int unsigned LEAD_W  = 1,
   parameter int unsigned STRB_W  = 4,
   parameter int unsigned TRAIL_W = 4,
   localparam int unsigned SET_W  = LEAD_W + STRB_W + TRAIL_W,
   localparam int unsigned TIM_W  = 2 * SET_W,
   localparam int unsigned CNT_W  = max_of3(LEAD_W, STRB_W, TRAIL_W)
) (
   input  logic [TIM_W-1:0]                  timing,
   input  logic                              is_write,
   output logic [NUM_PHASES-1:0][CNT_W-1:0]  lens
);

   if (LEAD_W < 1 || STRB_W < 1 || TRAIL_W < 1) begin : g_bad_width
      $error("pio_cfg_split: every phase field needs at least one bit");
   end

   for (genvar g = 0; g < NUM_PHASES; g++) begin : g_phase
      localparam int unsigned FW = (g == 0) ? LEAD_W : (g == 1) ? STRB_W : TRAIL_W;
      localparam int unsigned LO = (g == 0) ? 0 : (g == 1) ? LEAD_W : LEAD_W + STRB_W;
      logic [FW-1:0] fld_rd;
      logic [FW-1:0] fld_wr;
      assign fld_rd = timing[LO +: FW];
      assign fld_wr = timing[SET_W + LO +: FW];
      assign lens[g] = CNT_W'(is_write ? fld_wr : fld_rd);
   end

endmodule

// File: rtl/pio_phase_fsm.sv
module pio_phase_fsm
   import pio_seq_pkg::*;
#(
   parameter int unsigned CNT_W = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              start,
   input  logic [NUM_PHASES-1:0][CNT_W-1:0]  lens,
   output phase_e                            phase,
   output logic                              last
);

   if (CNT_W < 1) begin : g_bad_cnt
      $error("pio_phase_fsm: counter width must be positive");
   end

   logic [CNT_W-1:0] cnt;

   function automatic logic [CNT_W-1:0] first_cnt(input logic [CNT_W-1:0] n);
      return (n == '0) ? '0 : n - 1'b1;
   endfunction

   assign last = (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               if (start) begin
                  phase <= PH_LEAD;
                  cnt   <= first_cnt(lens[0]);
               end
            end
            PH_LEAD: begin
               if (last) begin
                  phase <= PH_STROBE;
                  cnt   <= first_cnt(lens[1]);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_STROBE: begin
               if (last) begin
                  phase <= PH_TRAIL;
                  cnt   <= first_cnt(lens[2]);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_TRAIL: begin
               if (last) phase <= PH_DONE;
               else      cnt   <= cnt - 1'b1;
            end
            PH_DONE:  phase <= PH_IDLE;
            default:  phase <= PH_IDLE;
         endcase
      end
   end

   AST_LEAD_TO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_LEAD && last) |=> (phase == PH_STROBE)); // R2
   AST_ZERO_IS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(phase) == PH_LEAD && phase == PH_STROBE && lens[1] == '0) |-> last); // R3
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DONE) |=> (phase == PH_IDLE)); // R7

endmodule

// File: rtl/pio_lane_steer.sv
module pio_lane_steer #(
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned BUS_W = 2 * BYTE_W
) (
   input  logic              wide,
   input  logic              even_hi,
   input  logic              addr0,
   input  logic [BUS_W-1:0]  wr_data,
   input  logic [BUS_W-1:0]  bus_in,
   output logic [BUS_W-1:0]  bus_out,
   output logic [BUS_W-1:0]  rd_data
);

   if (BYTE_W < 1) begin : g_bad_byte
      $error("pio_lane_steer: byte width must be positive");
   end

   localparam logic [BYTE_W-1:0] ZB = '0;

   logic on_hi;
   logic [BYTE_W-1:0] w_lo, w_hi, b_lo, b_hi;

   assign on_hi = addr0 ^ even_hi;
   assign w_lo  = wr_data[BYTE_W-1:0];
   assign w_hi  = wr_data[BUS_W-1:BYTE_W];
   assign b_lo  = bus_in[BYTE_W-1:0];
   assign b_hi  = bus_in[BUS_W-1:BYTE_W];

   always_comb begin
      if (wide) begin
         bus_out = even_hi ? {w_lo, w_hi} : {w_hi, w_lo};
         rd_data = even_hi ? {b_lo, b_hi} : {b_hi, b_lo};
      end else begin
         bus_out = on_hi ? {w_lo, ZB} : {ZB, w_lo};
         rd_data = {ZB, (on_hi ? b_hi : b_lo)};
      end
   end

endmodule

// File: rtl/pio_strobe_seq.sv
module pio_strobe_seq
   import pio_seq_pkg::*;
#(
   parameter int unsigned BYTE_W  = 8,
   parameter int unsigned LEAD_W  = 1,
   parameter int unsigned STRB_W  = 4,
   parameter int unsigned TRAIL_W = 4,
   localparam int unsigned BUS_W    = 2 * BYTE_W,
   localparam int unsigned SET_W    = LEAD_W + STRB_W + TRAIL_W,
   localparam int unsigned TIM_W    = 2 * SET_W,
   localparam int unsigned WIDE_BIT = TIM_W,
   localparam int unsigned EVHI_BIT = TIM_W + 1,
   localparam int unsigned CFG_W    = TIM_W + 2,
   localparam int unsigned CNT_W    = max_of3(LEAD_W, STRB_W, TRAIL_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              req_write,
   input  logic              req_addr0,
   input  logic [BUS_W-1:0]  req_wdata,
   input  logic [CFG_W-1:0]  cfg_word,
   output logic              busy,
   output logic              done,
   output logic [BUS_W-1:0]  rdata,
   output logic              dev_cs,
   output logic              dev_rd,
   output logic              dev_wr,
   output logic              dev_oe,
   output logic [BUS_W-1:0]  dev_dout,
   input  logic [BUS_W-1:0]  dev_din
);

   if (CNT_W > 16) begin : g_bad_len
      $error("pio_strobe_seq: phase fields wider than 16 bits are not supported");
   end

   phase_e                            phase;
   logic                              last;
   logic                              start;
   logic [CFG_W-1:0]                  cfg_q;
   logic [CFG_W-1:0]                  cfg_eff;
   logic                              wr_q, addr0_q;
   logic                              dir_eff, a0_eff;
   logic [NUM_PHASES-1:0][CNT_W-1:0]  lens;
   logic [BUS_W-1:0]                  steer_out, steer_rd;
   logic [BUS_W-1:0]                  dout_q, rdata_q;

   assign start   = req && (phase == PH_IDLE);
   assign cfg_eff = start ? cfg_word  : cfg_q;
   assign dir_eff = start ? req_write : wr_q;
   assign a0_eff  = start ? req_addr0 : addr0_q;

   pio_cfg_split #(
      .LEAD_W (LEAD_W),
      .STRB_W (STRB_W),
      .TRAIL_W(TRAIL_W)
   ) u_split (
      .timing  (cfg_eff[TIM_W-1:0]),
      .is_write(dir_eff),
      .lens    (lens)
   );

   pio_phase_fsm #(
      .CNT_W(CNT_W)
   ) u_fsm (
      .clk  (clk),
      .rst_n(rst_n),
      .start(start),
      .lens (lens),
      .phase(phase),
      .last (last)
   );

   pio_lane_steer #(
      .BYTE_W(BYTE_W)
   ) u_steer (
      .wide   (cfg_eff[WIDE_BIT]),
      .even_hi(cfg_eff[EVHI_BIT]),
      .addr0  (a0_eff),
      .wr_data(req_wdata),
      .bus_in (dev_din),
      .bus_out(steer_out),
      .rd_data(steer_rd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         wr_q    <= 1'b0;
         addr0_q <= 1'b0;
         dout_q  <= '0;
         rdata_q <= '0;
      end else begin
         if (start) begin
            cfg_q   <= cfg_word;
            wr_q    <= req_write;
            addr0_q <= req_addr0;
            dout_q  <= req_write ? steer_out : '0;
         end
         if (phase == PH_STROBE && last && !wr_q) begin
            rdata_q <= steer_rd;
         end
      end
   end

   assign dev_cs   = (phase == PH_LEAD) || (phase == PH_STROBE) || (phase == PH_TRAIL);
   assign dev_rd   = (phase == PH_STROBE) && !wr_q;
   assign dev_wr   = (phase == PH_STROBE) && wr_q;
   assign dev_oe   = dev_cs && wr_q;
   assign dev_dout = dout_q;
   assign done     = (phase == PH_DONE);
   assign busy     = (phase != PH_IDLE);
   assign rdata    = rdata_q;

   AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_rd || dev_wr) |-> dev_cs); // R2
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(dev_rd && dev_wr)); // R5
   AST_DONE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!dev_cs && $past(dev_cs))); // R7
   AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy); // R8
   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(cfg_q)); // R9
   AST_DOUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_oe && $past(dev_oe)) |-> $stable(dev_dout)); // R12

endmodule

// File: tb/tb_pio_strobe_seq.sv
module tb_pio_strobe_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic        req_write = 1'b0;
   logic        req_addr0 = 1'b0;
   logic [15:0] req_wdata = '0;
   logic [19:0] cfg_word = '0;
   logic        busy, done, dev_cs, dev_rd, dev_wr, dev_oe;
   logic [15:0] rdata, dev_dout;
   logic [15:0] dev_din = '0;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   pio_strobe_seq dut (
      .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
      .req_addr0(req_addr0), .req_wdata(req_wdata), .cfg_word(cfg_word),
      .busy(busy), .done(done), .rdata(rdata), .dev_cs(dev_cs),
      .dev_rd(dev_rd), .dev_wr(dev_wr), .dev_oe(dev_oe),
      .dev_dout(dev_dout), .dev_din(dev_din)
   );

   // access observation results
   int          r_cs, r_sst, r_slen, r_wrong, r_done;
   bit          r_busy_ok, r_oe_ok, r_cs_at_done, r_after;
   logic [15:0] r_dout;

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int ln(input int n);
      return (n == 0) ? 1 : n;
   endfunction

   function automatic logic [15:0] pat(input int i);
      return {8'(i * 7 + 49), 8'(i * 13 + 90)};
   endfunction

   function automatic logic [19:0] mk_cfg(input int wr, input int p2, input int p3, input int p4,
                                          input int wide, input int evh);
      logic [8:0] set, rds, wrs;
      set = {4'(p4), 4'(p3), 1'(p2)};
      rds = (wr != 0) ? 9'h1FF : set;
      wrs = (wr != 0) ? set : 9'h1FF;
      return {1'(evh), 1'(wide), wrs, rds};
   endfunction

   function automatic logic [15:0] exp_bus(input logic [15:0] wd, input bit wide, input bit evh,
                                           input bit a0);
      if (wide) return evh ? {wd[7:0], wd[15:8]} : wd;
      return (a0 ^ evh) ? {wd[7:0], 8'h00} : {8'h00, wd[7:0]};
   endfunction

   function automatic logic [15:0] exp_rd(input logic [15:0] b, input bit wide, input bit evh,
                                          input bit a0);
      if (wide) return evh ? {b[7:0], b[15:8]} : b;
      return {8'h00, ((a0 ^ evh) ? b[15:8] : b[7:0])};
   endfunction

   task automatic run_access(input bit wr, input logic [19:0] cfg, input logic [19:0] cfg_mid,
                             input bit a0, input logic [15:0] wd, input bit poke);
      int idx;
      bit stb, oth;
      @(negedge clk);
      cfg_word = cfg; req_write = wr; req_addr0 = a0; req_wdata = wd; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      idx = 0;
      r_cs = 0; r_sst = -1; r_slen = 0; r_wrong = 0; r_done = -1;
      r_busy_ok = 1; r_oe_ok = 1; r_cs_at_done = 0; r_dout = '0;
      while (r_done < 0 && idx < 200) begin
         dev_din = pat(idx);
         if (idx == 0) cfg_word = cfg_mid;
         if (poke) req = (idx == 1);
         if (!busy) r_busy_ok = 0;
         if (done) begin
            r_done = idx;
            r_cs_at_done = dev_cs;
         end else begin
            if (dev_cs) r_cs++;
            if (dev_oe != (wr & dev_cs)) r_oe_ok = 0;
            stb = wr ? dev_wr : dev_rd;
            oth = wr ? dev_rd : dev_wr;
            if (oth) r_wrong++;
            if (stb) begin
               if (r_sst < 0) begin
                  r_sst = idx;
                  r_dout = dev_dout;
               end
               r_slen++;
            end
            @(negedge clk);
            idx++;
         end
      end
      req = 1'b0;
      @(negedge clk);
      r_after = busy | dev_cs | done;
   endtask

   task automatic verify(input bit wr, input int p2, input int p3, input int p4, input bit wide,
                         input bit evh, input bit a0, input logic [15:0] wd, input string tag);
      int l2, l3, l4, tot;
      bit ok;
      l2 = ln(p2); l3 = ln(p3); l4 = ln(p4); tot = l2 + l3 + l4;
      ok = (r_cs == tot) && (r_sst == l2) && (r_slen == l3) && (r_wrong == 0);
      check(ok, {tag, " R2 R3 R4 R5 timing"},
            {16'(r_cs), 16'(r_sst), 16'(r_slen), 16'(r_wrong)},
            {16'(tot), 16'(l2), 16'(l3), 16'h0});
      ok = (r_done == tot) && !r_cs_at_done && r_busy_ok && !r_after;
      check(ok, {tag, " R7 R8 done/busy"},
            {16'(r_done), 8'(r_cs_at_done), 8'(r_busy_ok), 8'(r_after)},
            {16'(tot), 8'h0, 8'h1, 8'h0});
      if (wr) begin
         check(r_oe_ok && r_dout == exp_bus(wd, wide, evh, a0), {tag, " R10 R11 R12 write lane"},
               {15'h0, r_oe_ok, r_dout}, {16'h1, exp_bus(wd, wide, evh, a0)});
      end else begin
         check(r_oe_ok && rdata == exp_rd(pat(l2 + l3 - 1), wide, evh, a0),
               {tag, " R6 R10 R11 read capture"}, {15'h0, r_oe_ok, rdata},
               {16'h1, exp_rd(pat(l2 + l3 - 1), wide, evh, a0)});
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog R8 actual=%0d expected<=%0d", cycles, 150000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [19:0] c;
      logic [15:0] wd;
      // R1: reset state
      repeat (3) @(negedge clk);
      check(!busy && !done && !dev_cs && !dev_rd && !dev_wr && !dev_oe && rdata == 0,
            "R1 during reset", {busy, done, dev_cs, dev_rd, dev_wr, dev_oe, rdata}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!busy && !done && !dev_cs && !dev_rd && !dev_wr && !dev_oe && rdata == 0,
            "R1 after reset", {busy, done, dev_cs, dev_rd, dev_wr, dev_oe, rdata}, 0);

      // sweep every lead/strobe/trail count in both directions, rotating lane modes
      for (int wr = 0; wr < 2; wr++) begin
         for (int p2 = 0; p2 < 2; p2++) begin
            for (int p3 = 0; p3 < 16; p3++) begin
               for (int p4 = 0; p4 < 16; p4++) begin
                  bit wide, evh, a0;
                  wide = p3[0]; evh = p4[0]; a0 = p3[1] ^ p4[1];
                  wd = 16'(p3 * 4099 + p4 * 257 + p2 * 31 + wr * 7) ^ 16'hC3A5;
                  c = mk_cfg(wr, p2, p3, p4, wide, evh);
                  run_access(wr[0], c, c, a0, wd, 1'b0);
                  verify(wr[0], p2, p3, p4, wide, evh, a0, wd, "sweep");
               end
            end
         end
      end

      // R9: configuration changed right after acceptance must not affect the access
      for (int wr = 0; wr < 2; wr++) begin
         c = mk_cfg(wr, 1, 3, 2, 0, 1);
         wd = 16'hBEEF;
         run_access(wr[0], c, mk_cfg(1 - wr, 0, 9, 7, 1, 0), 1'b0, wd, 1'b0);
         verify(wr[0], 1, 3, 2, 1'b0, 1'b1, 1'b0, wd, "R9 cfg change");
      end

      // R8: request re-asserted while busy is dropped
      c = mk_cfg(0, 0, 4, 3, 1, 1);
      run_access(1'b0, c, c, 1'b1, 16'h0, 1'b1);
      verify(1'b0, 0, 4, 3, 1'b1, 1'b1, 1'b1, 16'h0, "R8 request while busy");
      @(negedge clk);
      check(!busy && !dev_cs, "R8 no queued access", {busy, dev_cs}, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule